// File: doc/BRIEF.md
# Real-Time Clock Interrupt Controller

This block gathers the three interrupt sources of a real-time clock: a periodic tick, an alarm match and an end-of-update strobe. Each strobe sets a sticky flag. The flag is set whether or not its source is enabled. Each flag is then gated by its own enable bit, and the gated flags are combined into one active-low interrupt line. Software finds the cause by reading the flag register, and that read also clears every flag and lets the interrupt line go high again.

The same register port holds the control bits. These are a hold bit that freezes time updates while software sets the clock, the three source enables, and a square-wave enable. A separate register holds a 4-bit rate select. The square-wave output takes one of sixteen divider taps supplied from outside the block. An override input replaces that choice with an external fast clock. The block does not generate events and does not count the periodic rate; both arrive on its inputs.

All register reads return data in the cycle after the read strobe. Both outputs are registered.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq_n` is 1, `sqw` is 0, the flags are clear, and the control and rate registers read 0.
- R2: A high event strobe (`evt_periodic`, `evt_alarm` or `evt_update`) sets its flag at the next clock edge, whatever the state of its enable. The flag register places the periodic flag at bit 0, the alarm flag at bit 1 and the update flag at bit 2.
- R3: `irq_n` is active low. It goes low one cycle after any flag is set while its enable is 1. It is high in every other case.
- R4: A read at address 2 returns the flags. Bit 7 of that read is the OR of each flag ANDed with its enable. The same clock edge clears all flags, and `irq_n` returns high one cycle later.
- R5: An event strobe that arrives in the same cycle as a flag read wins over the clear. Its flag stays set, and the read returns the flag value from before that edge.
- R6: The control register is at address 0. Bit 0 is the hold bit, bit 1 the periodic enable, bit 2 the alarm enable, bit 3 the update enable and bit 4 the square-wave enable. Reads return these bits with zeros above them.
- R7: A control write that takes the hold bit from 0 to 1 forces the update enable to 0, whatever value was written to bit 3. A write made while hold is already 1 stores bit 3 as written.
- R8: `sqw` is registered and follows its inputs one cycle later. When `ovr_en` is 1 it copies `ovr_clk`. Otherwise, when the square-wave enable is 1 and the rate select is not 0, it copies `rate_taps[rate_select]`. In every other case it is 0.
- R9: A write to the flag address (2) has no effect on the flags.
- R10: The rate select register is at address 1, in its low 4 bits. Reads at address 3 return 0. Read data appears in the cycle after `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_periodic | input | 1 | One-cycle periodic tick strobe |
| evt_alarm | input | 1 | One-cycle alarm match strobe |
| evt_update | input | 1 | One-cycle update-ended strobe |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| rate_taps | input | 16 | Divider taps chosen by the rate select |
| ovr_en | input | 1 | Fast-clock override for the square wave |
| ovr_clk | input | 1 | Fast clock used during override |
| irq_n | output | 1 | Active-low interrupt |
| sqw | output | 1 | Square-wave output |

## Verification
The bench goes after sources that are disabled but still flag. A design that gated the flag instead of the interrupt line would read back zero flags in those cases. It checks the hold-bit rising edge against a write made while hold is already set. A design that cleared the update enable on the level of the hold bit would lose a later enable written in hold mode. It checks a strobe that lands on the same edge as a flag read: if the clear won, that event would be dropped. It also checks rate select 0 with tap 0 high, where a design that used the plain tap would toggle `sqw`. Finally, a write to the flag address must not disturb pending flags.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int ADDR_W = 2;
  localparam int NSRC   = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RATE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;

  // control register bit positions
  localparam int CB_HOLD = 0;
  localparam int CB_EN0  = 1;
  localparam int CB_SQW  = 4;

  // source indices (also flag bit positions)
  localparam int SRC_PER = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_UPD = 2;

  localparam int FB_IRQ = 7;
endpackage

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              hold,
  output logic [NSRC-1:0]   src_en,
  output logic              sqw_en,
  output logic [RSEL_W-1:0] rsel
);
  logic hold_rise;
  assign hold_rise = !hold && wdata[CB_HOLD];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= 1'b0;
      src_en <= '0;
      sqw_en <= 1'b0;
      rsel   <= '0;
    end else if (we) begin
      if (addr == ADDR_CTRL) begin
        hold   <= wdata[CB_HOLD];
        sqw_en <= wdata[CB_SQW];
        src_en <= wdata[CB_EN0 +: NSRC];
        if (hold_rise) src_en[SRC_UPD] <= 1'b0;
      end
      if (addr == ADDR_RATE) rsel <= wdata[RSEL_W-1:0];
    end
  end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic            clr,
  input  logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] flag_q,
  output logic            irq_n
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flag_q[i] <= 1'b0;
      else if (evt[i]) flag_q[i] <= 1'b1;
      else if (clr)    flag_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~|(flag_q & src_en);
  end
endmodule

// File: rtl/rtc_irq_sqw.sv
module rtc_irq_sqw #(
  parameter int RSEL_W = 4,
  localparam int TAP_N = 1 << RSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sqw_en,
  input  logic [RSEL_W-1:0] rsel,
  input  logic [TAP_N-1:0]  taps,
  input  logic              ovr_en,
  input  logic              ovr_clk,
  output logic              sqw
);
  logic nxt;
  always_comb begin
    if (ovr_en)                           nxt = ovr_clk;
    else if (sqw_en && (rsel != '0))      nxt = taps[rsel];
    else                                  nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) sqw <= 1'b0;
    else     sqw <= nxt;
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RSEL_W = 4,
  localparam int TAP_N = 1 << RSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_periodic,
  input  logic              evt_alarm,
  input  logic              evt_update,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [TAP_N-1:0]  rate_taps,
  input  logic              ovr_en,
  input  logic              ovr_clk,
  output logic              irq_n,
  output logic              sqw
);
  logic              hold;
  logic              sqw_en;
  logic [NSRC-1:0]   src_en;
  logic [RSEL_W-1:0] rsel;
  logic [NSRC-1:0]   flag_q;
  logic [NSRC-1:0]   evt_vec;
  logic              flag_rd;

  assign evt_vec = {evt_update, evt_alarm, evt_periodic};
  assign flag_rd = reg_re && (reg_addr == ADDR_FLAG);

  rtc_irq_regs #(.DATA_W(DATA_W), .RSEL_W(RSEL_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .hold(hold), .src_en(src_en), .sqw_en(sqw_en), .rsel(rsel)
  );

  rtc_irq_flags u_flags (
    .clk(clk), .rst(rst), .evt(evt_vec), .clr(flag_rd), .src_en(src_en),
    .flag_q(flag_q), .irq_n(irq_n)
  );

  rtc_irq_sqw #(.RSEL_W(RSEL_W)) u_sqw (
    .clk(clk), .rst(rst), .sqw_en(sqw_en), .rsel(rsel), .taps(rate_taps),
    .ovr_en(ovr_en), .ovr_clk(ovr_clk), .sqw(sqw)
  );

  logic [DATA_W-1:0] ctrl_view, rate_view, flag_view, rd_nxt;
  always_comb begin
    ctrl_view = '0;
    ctrl_view[CB_HOLD] = hold;
    ctrl_view[CB_EN0 +: NSRC] = src_en;
    ctrl_view[CB_SQW] = sqw_en;
    rate_view = '0;
    rate_view[RSEL_W-1:0] = rsel;
    flag_view = '0;
    flag_view[NSRC-1:0] = flag_q;
    flag_view[FB_IRQ] = |(flag_q & src_en);
    case (reg_addr)
      ADDR_CTRL: rd_nxt = ctrl_view;
      ADDR_RATE: rd_nxt = rate_view;
      ADDR_FLAG: rd_nxt = flag_view;
      default:   rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_nxt;
  end
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk
  import rtc_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   flag_q,
  input logic [NSRC-1:0]   src_en,
  input logic [NSRC-1:0]   evt_vec,
  input logic              hold,
  input logic              sqw_en,
  input logic              ovr_en,
  input logic              sqw,
  input logic              irq_n,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr
);
  assert_irq_low_R3: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & src_en)) |=> !irq_n);

  assert_irq_high_R3: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_q & src_en)) |=> irq_n);

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (evt_vec != '0) |=> ((flag_q & $past(evt_vec)) == $past(evt_vec)));

  assert_read_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_addr == ADDR_FLAG && evt_vec == '0) |=> (flag_q == '0));

  assert_hold_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> !src_en[SRC_UPD]);

  assert_sqw_off_R8: assert property (@(posedge clk) disable iff (rst)
    (!ovr_en && !sqw_en) |=> !sqw);
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .flag_q(flag_q), .src_en(src_en), .evt_vec(evt_vec),
  .hold(hold), .sqw_en(sqw_en), .ovr_en(ovr_en), .sqw(sqw), .irq_n(irq_n),
  .reg_re(reg_re), .reg_addr(reg_addr)
);

// File: tb/rtc_irq_ctrl_tb.sv
module rtc_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_periodic = 0, evt_alarm = 0, evt_update = 0;
  logic        reg_we = 0, reg_re = 0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] rate_taps = 16'hA5C3;
  logic        ovr_en = 0, ovr_clk = 0;
  logic        irq_n, sqw;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .evt_periodic(evt_periodic), .evt_alarm(evt_alarm),
    .evt_update(evt_update), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rate_taps(rate_taps),
    .ovr_en(ovr_en), .ovr_clk(ovr_clk), .irq_n(irq_n), .sqw(sqw)
  );

  // vector: {enables[2:0], events[2:0], expected irq_n, expected flag byte}
  localparam int NV = 9;
  localparam logic [14:0] VEC [NV] = '{
    {3'b000, 3'b001, 1'b1, 8'h01},
    {3'b001, 3'b001, 1'b0, 8'h81},
    {3'b010, 3'b001, 1'b1, 8'h01},
    {3'b010, 3'b010, 1'b0, 8'h82},
    {3'b100, 3'b100, 1'b0, 8'h84},
    {3'b100, 3'b011, 1'b1, 8'h03},
    {3'b111, 3'b111, 1'b0, 8'h87},
    {3'b011, 3'b100, 1'b1, 8'h04},
    {3'b000, 3'b000, 1'b1, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_re = 1; reg_addr = a;
    @(negedge clk);
    reg_re = 0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [2:0] e);
    {evt_update, evt_alarm, evt_periodic} = e;
    @(negedge clk);
    {evt_update, evt_alarm, evt_periodic} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_n", irq_n, 1);
    check("R1 sqw", sqw, 0);
    rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    rd(2'd1, d); check("R1 rate", d, 8'h00);
    rd(2'd2, d); check("R1 flags", d, 8'h00);

    // table walk: R2, R3, R4
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {4'b0, VEC[i][14:12], 1'b0});
      pulse(VEC[i][11:9]);
      @(negedge clk);
      check("R3 irq_n after event", irq_n, VEC[i][8]);
      rd(2'd2, d);
      check("R2/R4 flag read", d, VEC[i][7:0]);
      @(negedge clk);
      check("R4 irq released", irq_n, 1);
      rd(2'd2, d);
      check("R4 flags cleared", d, 8'h00);
    end

    // R6 / R7 control layout and hold behaviour
    wr(2'd0, 8'h0E);
    rd(2'd0, d); check("R6 ctrl readback", d, 8'h0E);
    wr(2'd0, 8'h0F);
    rd(2'd0, d); check("R7 hold rise clears update enable", d, 8'h07);
    wr(2'd0, 8'h0F);
    rd(2'd0, d); check("R7 hold held keeps update enable", d, 8'h0F);
    wr(2'd0, 8'h1F);
    rd(2'd0, d); check("R6 sqw enable bit", d, 8'h1F);

    // R9 write to flag address ignored
    wr(2'd0, 8'h00);
    pulse(3'b010);
    wr(2'd2, 8'h00);
    rd(2'd2, d); check("R9 flag write ignored", d, 8'h02);

    // R5 event coincides with flag read
    {evt_update, evt_alarm, evt_periodic} = 3'b001;
    rd(2'd2, d);
    {evt_update, evt_alarm, evt_periodic} = '0;
    check("R5 read returns old flags", d, 8'h00);
    rd(2'd2, d); check("R5 event survives clear", d, 8'h01);

    // R10 rate register and unused address
    wr(2'd1, 8'hF5);
    rd(2'd1, d); check("R10 rate readback", d, 8'h05);
    rd(2'd3, d); check("R10 addr 3 reads zero", d, 8'h00);

    // R8 square wave, taps = A5C3
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h01); @(negedge clk); check("R8 tap1", sqw, 1);
    wr(2'd1, 8'h02); @(negedge clk); check("R8 tap2", sqw, 0);
    wr(2'd1, 8'h0F); @(negedge clk); check("R8 tap15", sqw, 1);
    wr(2'd1, 8'h00); @(negedge clk); check("R8 rate 0 low", sqw, 0);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h00); @(negedge clk); check("R8 disabled low", sqw, 0);
    ovr_en = 1; ovr_clk = 1;
    @(negedge clk); check("R8 override high", sqw, 1);
    ovr_clk = 0;
    @(negedge clk); check("R8 override low", sqw, 0);
    ovr_en = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule